// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block is a small set-associative cache that sits beside the instruction fetcher. Its key is the address of a branch instruction. Each entry holds the first two instruction words found at that branch's target. When the fetcher meets a branch it has seen before, a lookup returns both target words one clock later. The fetch queue can then carry on down the target path without waiting for the instruction cache.

The storage is organised as 16 sets of 4 ways, which gives 64 entries. Entries are written through a fill port by the fetch path once the target words are known. A configuration enable gates all use of the table. A configuration invalidate bit, and four coherency events, each clear the whole table in a single cycle. The four events are an instruction-cache flash invalidate, an executed cache-block invalidate, an executed return-from-interrupt, and an exception being taken.

Top module: `btic_top`

## Requirements
- R1: After reset every entry is invalid, and `hitOut`, `hitInsn0` and `hitInsn1` are 0.
- R2: A lookup of an address that holds an entry sets `hitOut` and returns the two stored words. The result appears at the clock edge that follows the edge sampling `lookupValid`. The set index is address bits [5:2] and the tag is bits [31:6]. Bits [1:0] are ignored.
- R3: A lookup that misses, and every cycle with no lookup, gives `hitOut` = 0 and both words 0.
- R4: While `cfgEnable` is 0, every lookup misses and every fill is discarded. Entries written before disabling survive and hit again once the cache is re-enabled.
- R5: `cfgInvalidate` high clears all entries at the next edge. A lookup in the same cycle misses. A fill in the same cycle is dropped.
- R6: `icFlashInval`, `icbiExec`, `rfiExec` and `exceptionTaken` each clear the whole table exactly as R5 does.
- R7: A fill whose address already holds an entry overwrites that entry's words in place and takes no second way.
- R8: A fill into a set that has an invalid way uses an invalid way, so four distinct tags in one set all stay resident.
- R9: With all four ways valid, the victim follows a 3-bit tree pseudo-LRU that is updated on every hit and fill. Filling tags A, B, C, D in order and then a fifth tag evicts A. If A is hit before the fifth fill, C is evicted instead.
- R10: A lookup in the same cycle as a fill of the same address sees the table before that fill. The next lookup hits.
- R11: Fills and replacements in one set leave the entries of every other set untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupAddr | input | 32 | Branch address to look up |
| fillValid | input | 1 | Fill request this cycle |
| fillAddr | input | 32 | Branch address of the fill |
| fillInsn0 | input | 32 | First target instruction word |
| fillInsn1 | input | 32 | Second target instruction word |
| cfgEnable | input | 1 | Cache enable from configuration |
| cfgInvalidate | input | 1 | Whole-table invalidate from configuration |
| icFlashInval | input | 1 | Instruction-cache flash invalidate event |
| icbiExec | input | 1 | Cache-block invalidate instruction executed |
| rfiExec | input | 1 | Return-from-interrupt executed |
| exceptionTaken | input | 1 | Exception taken |
| hitOut | output | 1 | Registered lookup hit |
| hitInsn0 | output | 32 | First target word on a hit, else 0 |
| hitInsn1 | output | 32 | Second target word on a hit, else 0 |

## Verification
A lookup result is due one edge after `lookupValid` is sampled. A fill or a flush becomes visible to a lookup that is sampled one edge later. The bench drives every request on a falling edge and drops it on the next falling edge. It then reads `hitOut` and both words on that second falling edge, half a period after the register has updated. Same-cycle cases drive the fill or flush and the lookup on the same falling edge. The bench then expects the result from the table as it stood before that edge.

// File: rtl/btic_pkg.sv
package btic_pkg;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;
  localparam int PLRU_W   = NUM_WAYS - 1;

  typedef struct packed {
    logic flushAll;
    logic lookupEn;
    logic fillEn;
  } btic_strobe_t;

  // Tree bits: [0] picks the half (0 = ways 0/1), [1] picks within the
  // low half (0 = way 0), [2] picks within the high half (0 = way 2).
  function automatic logic [WAY_W-1:0] plruVictim(input logic [PLRU_W-1:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    else       return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [PLRU_W-1:0] plruTouch(input logic [PLRU_W-1:0] t,
                                                  input logic [WAY_W-1:0] w);
    logic [PLRU_W-1:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction
endpackage

// File: rtl/btic_ctrl.sv
module btic_ctrl
  import btic_pkg::*;
(
  input  logic         lookupValid,
  input  logic         fillValid,
  input  logic         cfgEnable,
  input  logic         cfgInvalidate,
  input  logic         icFlashInval,
  input  logic         icbiExec,
  input  logic         rfiExec,
  input  logic         exceptionTaken,
  output btic_strobe_t strobes
);
  logic anyFlush;

  always_comb begin
    anyFlush         = cfgInvalidate | icFlashInval | icbiExec | rfiExec | exceptionTaken;
    strobes.flushAll = anyFlush;
    strobes.lookupEn = lookupValid & cfgEnable & ~anyFlush;
    strobes.fillEn   = fillValid & cfgEnable & ~anyFlush;
  end
endmodule

// File: rtl/btic_datapath.sv
module btic_datapath
  import btic_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  btic_strobe_t      strobes,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [INSN_W-1:0] fillInsn0,
  input  logic [INSN_W-1:0] fillInsn1,
  output logic              hitOut,
  output logic [INSN_W-1:0] hitInsn0,
  output logic [INSN_W-1:0] hitInsn1
);
  localparam int OFF_W = 2;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;

  logic [NUM_WAYS-1:0] validQ [SETS];
  logic [TAG_W-1:0]    tagQ   [SETS][NUM_WAYS];
  logic [INSN_W-1:0]   word0Q [SETS][NUM_WAYS];
  logic [INSN_W-1:0]   word1Q [SETS][NUM_WAYS];
  logic [PLRU_W-1:0]   plruQ  [SETS];

  logic [SET_W-1:0] lkSet, fSet;
  logic [TAG_W-1:0] lkTag, fTag;
  logic [NUM_WAYS-1:0] lkHitVec, fMatchVec;
  logic [WAY_W-1:0] lkWay, fWay;
  logic lkHit;
  logic unusedBits;

  assign lkSet = lookupAddr[OFF_W +: SET_W];
  assign lkTag = lookupAddr[ADDR_W-1 -: TAG_W];
  assign fSet  = fillAddr[OFF_W +: SET_W];
  assign fTag  = fillAddr[ADDR_W-1 -: TAG_W];
  assign unusedBits = ^{lookupAddr[OFF_W-1:0], fillAddr[OFF_W-1:0]};

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign lkHitVec[w]  = validQ[lkSet][w] && (tagQ[lkSet][w] == lkTag);
    assign fMatchVec[w] = validQ[fSet][w] && (tagQ[fSet][w] == fTag);
  end

  always_comb begin
    lkWay = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (lkHitVec[w]) lkWay = WAY_W'(w);
    lkHit = strobes.lookupEn && (|lkHitVec);
  end

  // Existing entry first, then lowest invalid way, then the tree victim.
  always_comb begin
    fWay = plruVictim(plruQ[fSet]);
    if (|fMatchVec) begin
      for (int w = NUM_WAYS - 1; w >= 0; w--)
        if (fMatchVec[w]) fWay = WAY_W'(w);
    end else if (~&validQ[fSet]) begin
      for (int w = NUM_WAYS - 1; w >= 0; w--)
        if (!validQ[fSet][w]) fWay = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (strobes.flushAll) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (strobes.fillEn) begin
      validQ[fSet][fWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.fillEn) begin
      tagQ[fSet][fWay]   <= fTag;
      word0Q[fSet][fWay] <= fillInsn0;
      word1Q[fSet][fWay] <= fillInsn1;
    end
  end

  // A fill into the same set as a hit in the same cycle takes precedence.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) plruQ[s] <= '0;
    end else begin
      if (lkHit)          plruQ[lkSet] <= plruTouch(plruQ[lkSet], lkWay);
      if (strobes.fillEn) plruQ[fSet]  <= plruTouch(plruQ[fSet], fWay);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitOut   <= 1'b0;
      hitInsn0 <= '0;
      hitInsn1 <= '0;
    end else begin
      hitOut   <= lkHit;
      hitInsn0 <= lkHit ? word0Q[lkSet][lkWay] : '0;
      hitInsn1 <= lkHit ? word1Q[lkSet][lkWay] : '0;
    end
  end

  // R9: a fill never lands on a way already valid unless the set is full or it matches
  a_r9_fill_way_choice: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fillEn && !(|fMatchVec) && !(&validQ[fSet]) |-> !validQ[fSet][fWay]);

  // R7: at most one way holds a given tag
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fMatchVec) && $onehot0(lkHitVec));
endmodule

// File: rtl/btic_top.sv
module btic_top
  import btic_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [INSN_W-1:0] fillInsn0,
  input  logic [INSN_W-1:0] fillInsn1,
  input  logic              cfgEnable,
  input  logic              cfgInvalidate,
  input  logic              icFlashInval,
  input  logic              icbiExec,
  input  logic              rfiExec,
  input  logic              exceptionTaken,
  output logic              hitOut,
  output logic [INSN_W-1:0] hitInsn0,
  output logic [INSN_W-1:0] hitInsn1
);
  btic_strobe_t strobes;

  btic_ctrl u_ctrl (
    .lookupValid   (lookupValid),
    .fillValid     (fillValid),
    .cfgEnable     (cfgEnable),
    .cfgInvalidate (cfgInvalidate),
    .icFlashInval  (icFlashInval),
    .icbiExec      (icbiExec),
    .rfiExec       (rfiExec),
    .exceptionTaken(exceptionTaken),
    .strobes       (strobes)
  );

  btic_datapath #(.SETS(SETS), .ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .lookupAddr(lookupAddr),
    .fillAddr  (fillAddr),
    .fillInsn0 (fillInsn0),
    .fillInsn1 (fillInsn1),
    .hitOut    (hitOut),
    .hitInsn0  (hitInsn0),
    .hitInsn1  (hitInsn1)
  );

  logic portFlush;
  assign portFlush = cfgInvalidate | icFlashInval | icbiExec | rfiExec | exceptionTaken;

  a_r2_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rstN)
    hitOut |-> $past(lookupValid));

  a_r4_disabled_miss: assert property (@(posedge clk) disable iff (!rstN)
    $past(!cfgEnable) |-> !hitOut);

  a_r5_flush_same_cycle_miss: assert property (@(posedge clk) disable iff (!rstN)
    $past(portFlush) |-> !hitOut);

  // R6: nothing survives a flush into the lookup after it
  a_r6_flush_then_empty: assert property (@(posedge clk) disable iff (!rstN)
    $past(portFlush, 2) |-> !hitOut);

  a_r3_miss_words_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hitOut |-> (hitInsn0 == '0) && (hitInsn1 == '0));
endmodule

// File: tb/btic_top_test.sv
module btic_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic fillValid = 1'b0;
  logic [31:0] fillAddr = '0;
  logic [31:0] fillInsn0 = '0;
  logic [31:0] fillInsn1 = '0;
  logic cfgEnable = 1'b1;
  logic cfgInvalidate = 1'b0;
  logic icFlashInval = 1'b0;
  logic icbiExec = 1'b0;
  logic rfiExec = 1'b0;
  logic exceptionTaken = 1'b0;
  logic hitOut;
  logic [31:0] hitInsn0, hitInsn1;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  btic_top uut (.*);

  function automatic logic [31:0] mkAddr(input int tag, input int set);
    return {26'(tag), 4'(set), 2'b00};
  endfunction

  function automatic logic [31:0] w0Of(input int tag, input int set);
    return 32'hA000_0000 | (32'(tag) << 8) | 32'(set);
  endfunction

  function automatic logic [31:0] w1Of(input int tag, input int set);
    return 32'h5000_0000 | (32'(tag) << 8) | 32'(set);
  endfunction

  task automatic expect3(input string req, input bit eHit,
                         input logic [31:0] e0, input logic [31:0] e1);
    checkCount++;
    if (hitOut !== eHit || hitInsn0 !== e0 || hitInsn1 !== e1) begin
      failCount++;
      $display("FAIL %s: got hit=%0b w0=%h w1=%h, expected hit=%0b w0=%h w1=%h",
               req, hitOut, hitInsn0, hitInsn1, eHit, e0, e1);
    end
  endtask

  task automatic doFill(input int tag, input int set);
    @(negedge clk);
    fillValid = 1; fillAddr = mkAddr(tag, set);
    fillInsn0 = w0Of(tag, set); fillInsn1 = w1Of(tag, set);
    @(negedge clk);
    fillValid = 0;
  endtask

  task automatic doLookup(input logic [31:0] addr);
    @(negedge clk);
    lookupValid = 1; lookupAddr = addr;
    @(negedge clk);
    lookupValid = 0;
  endtask

  task automatic expectHit(input string req, input int tag, input int set);
    doLookup(mkAddr(tag, set));
    expect3(req, 1'b1, w0Of(tag, set), w1Of(tag, set));
  endtask

  task automatic expectMiss(input string req, input int tag, input int set);
    doLookup(mkAddr(tag, set));
    expect3(req, 1'b0, '0, '0);
  endtask

  task automatic flushAll();
    @(negedge clk); cfgInvalidate = 1;
    @(negedge clk); cfgInvalidate = 0;
  endtask

  task automatic testReset();
    expect3("R1 reset outputs", 1'b0, '0, '0);
    expectMiss("R1 empty after reset", 1, 0);
  endtask

  task automatic testBasic();
    doFill(3, 2);
    expectHit("R2 basic hit", 3, 2);
    doLookup(mkAddr(3, 2) | 32'h3);
    expect3("R2 low bits ignored", 1'b1, w0Of(3, 2), w1Of(3, 2));
    expectMiss("R3 other tag miss", 4, 2);
    @(negedge clk);
    expect3("R3 idle cycle zero", 1'b0, '0, '0);
    flushAll();
  endtask

  task automatic testDisable();
    cfgEnable = 0;
    doFill(6, 4);
    cfgEnable = 1;
    expectMiss("R4 fill ignored while disabled", 6, 4);
    doFill(6, 4);
    cfgEnable = 0;
    expectMiss("R4 lookup misses while disabled", 6, 4);
    cfgEnable = 1;
    expectHit("R4 entry survives disable", 6, 4);
    flushAll();
  endtask

  task automatic testCfgInvalidate();
    doFill(8, 6);
    @(negedge clk);
    cfgInvalidate = 1; lookupValid = 1; lookupAddr = mkAddr(8, 6);
    @(negedge clk);
    cfgInvalidate = 0; lookupValid = 0;
    expect3("R5 lookup with invalidate misses", 1'b0, '0, '0);
    expectMiss("R5 table cleared", 8, 6);
    @(negedge clk);
    cfgInvalidate = 1; fillValid = 1; fillAddr = mkAddr(9, 6);
    fillInsn0 = w0Of(9, 6); fillInsn1 = w1Of(9, 6);
    @(negedge clk);
    cfgInvalidate = 0; fillValid = 0;
    expectMiss("R5 fill with invalidate dropped", 9, 6);
  endtask

  task automatic testEvents();
    for (int e = 0; e < 4; e++) begin
      doFill(10 + e, 8);
      expectHit("R6 present before event", 10 + e, 8);
      @(negedge clk);
      case (e)
        0: icFlashInval = 1;
        1: icbiExec = 1;
        2: rfiExec = 1;
        default: exceptionTaken = 1;
      endcase
      @(negedge clk);
      icFlashInval = 0; icbiExec = 0; rfiExec = 0; exceptionTaken = 0;
      expectMiss("R6 cleared by event", 10 + e, 8);
    end
  endtask

  task automatic testOverwrite();
    doFill(20, 7);
    @(negedge clk);
    fillValid = 1; fillAddr = mkAddr(20, 7);
    fillInsn0 = 32'h1234_5678; fillInsn1 = 32'h9ABC_DEF0;
    @(negedge clk);
    fillValid = 0;
    doLookup(mkAddr(20, 7));
    expect3("R7 overwrite in place", 1'b1, 32'h1234_5678, 32'h9ABC_DEF0);
    doFill(21, 7); doFill(22, 7); doFill(23, 7);
    doLookup(mkAddr(20, 7));
    expect3("R7 no duplicate way used", 1'b1, 32'h1234_5678, 32'h9ABC_DEF0);
    expectHit("R7 neighbour kept", 23, 7);
    flushAll();
  endtask

  task automatic testInvalidFirst();
    for (int t = 30; t < 34; t++) doFill(t, 10);
    for (int t = 30; t < 34; t++) expectHit("R8 four tags resident", t, 10);
    flushAll();
  endtask

  task automatic testPlru();
    for (int t = 1; t < 5; t++) doFill(t, 5);
    doFill(5, 5);
    expectMiss("R9 oldest evicted", 1, 5);
    expectHit("R9 newest present", 5, 5);
    expectHit("R9 B kept", 2, 5);
    for (int t = 1; t < 5; t++) doFill(t, 3);
    expectHit("R9 touch A", 1, 3);
    doFill(5, 3);
    expectMiss("R9 C evicted after A hit", 3, 3);
    expectHit("R9 A kept", 1, 3);
    expectHit("R9 B kept after hit", 2, 3);
    expectHit("R9 D kept", 4, 3);
    flushAll();
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    fillValid = 1; fillAddr = mkAddr(40, 9);
    fillInsn0 = w0Of(40, 9); fillInsn1 = w1Of(40, 9);
    lookupValid = 1; lookupAddr = mkAddr(40, 9);
    @(negedge clk);
    fillValid = 0; lookupValid = 0;
    expect3("R10 same-cycle lookup sees old", 1'b0, '0, '0);
    expectHit("R10 hit next lookup", 40, 9);
    flushAll();
  endtask

  task automatic testSets();
    doFill(50, 1);
    for (int t = 60; t < 65; t++) doFill(t, 0);
    expectHit("R11 other set untouched", 50, 1);
    flushAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testBasic();
    testDisable();
    testCfgInvalidate();
    testEvents();
    testOverwrite();
    testInvalidFirst();
    testPlru();
    testSameCycle();
    testSets();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checkCount++;
      failCount++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule